// File: doc/BRIEF.md
# Deferred Condition-Flag Evaluator

This unit rebuilds the four integer condition flags (negative, zero, overflow, carry) after the ALU operation that produced them is gone. A processor that skips flag updates on every instruction keeps three things instead: a code for the kind of the last operation, the result word, and the source operand. When a later instruction needs the flags, this unit recovers them. Carry and overflow are worked out again from the result and the source alone. For the add forms the other operand is the result minus the source. For the subtract forms the minuend is the result plus the source. Each extend variant folds the incoming extend bit in as an extra one.

The caller presents the mode code and the two saved words. The flag vector and an error bit appear on registered outputs one clock later. The caller keeps the extend flag, merges any sticky zero across multi-word operations, and orders the operand words. This unit does none of those.

Top module: `deferFlagUnit`

## Requirements
- R1: With mode code 0 (direct), the flag output equals bits 3:0 of the result word. The flag vector is ordered {N,Z,V,C}, with C in bit 0 and N in bit 3.
- R2: In every mode other than direct and invalid, Z is set exactly when the evaluated value is zero. N is set exactly when that value is nonzero and its top bit is one, so N and Z are never both set.
- R3: With mode code 1 (logic), N and Z follow R2 over the full word, and V and C are zero.
- R4: With mode code 2 (add), C is set when the result is unsigned-below the source. V is set when the result's sign differs from the source's sign while the rebuilt operand (result minus source) has the source's sign.
- R5: With mode code 6 (add with extend), C is set when the result is unsigned-below-or-equal to the source. V follows the R4 rule with the rebuilt operand taken as result minus source minus one.
- R6: With mode code 3 (subtract), the minuend is rebuilt as result plus source. C is set when the minuend is unsigned-below the source. V is set when the minuend's sign differs from both the result's sign and the source's sign.
- R7: With mode code 7 (subtract with extend), the minuend is rebuilt as result plus source plus one. C is set when the minuend is unsigned-below-or-equal to the source, and V follows the R6 rule.
- R8: With mode code 4 (byte compare), the R6 rules apply to bits 7:0 of both words only. N, Z, V and C all come from that byte, and the upper bits have no effect.
- R9: With mode code 5 (halfword compare), the R6 rules apply to bits 15:0 of both words only, and the upper bits have no effect.
- R10: With mode code 8 (shift), N and Z follow R2 over the full word, C is set when the source word is nonzero, and V is zero.
- R11: Mode codes 9 to 15 drive all four flags to zero and set the error output. Valid codes leave the error output low.
- R12: Outputs are registered: inputs sampled at one rising edge appear at the outputs after that edge. While reset is low, the flags and the error output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeCode | input | 4 | Saved operation kind |
| resWord | input | DATA_W | Saved result word |
| srcWord | input | DATA_W | Saved source operand |
| flagsOut | output | 4 | Rebuilt flags {N,Z,V,C} |
| errOut | output | 1 | Mode code not recognised |

## Verification
Every result is due exactly one rising edge after its inputs are applied. The bench changes inputs on the falling edge and compares both outputs on the next falling edge, against a behavioural model evaluated on the inputs that were applied. Every clock after reset is compared this way, including directed corner words (zero results, sign-boundary overflow, equal operands under the extend modes, dirty upper bits under the narrow compares) and a long pseudo-random run across all sixteen codes.

// File: rtl/deferFlagPkg.sv
package deferFlagPkg;

  localparam int MODE_W = 4;
  localparam int FLAG_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_DIRECT = 4'd0,
    MODE_LOGIC  = 4'd1,
    MODE_ADD    = 4'd2,
    MODE_SUB    = 4'd3,
    MODE_CMPB   = 4'd4,
    MODE_CMPW   = 4'd5,
    MODE_ADDX   = 4'd6,
    MODE_SUBX   = 4'd7,
    MODE_SHIFT  = 4'd8
  } modeKind_e;

  // lane selection: which operand width the flags are judged at
  typedef enum logic [1:0] {
    LANE_FULL = 2'd0,
    LANE_HALF = 2'd1,
    LANE_BYTE = 2'd2
  } laneSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     passThru;
    logic     useNz;
    logic     useAdd;
    logic     useSub;
    logic     useShift;
    logic     extIn;
    laneSel_e laneSel;
    logic     badMode;
  } flagStrobe_t;

endpackage

// File: rtl/deferFlagCtrl.sv
module deferFlagCtrl
  import deferFlagPkg::*;
(
  input  logic [MODE_W-1:0] modeCode,
  output flagStrobe_t       strobes
);

  always_comb begin
    strobes          = '0;
    strobes.laneSel  = LANE_FULL;
    unique case (modeCode)
      MODE_DIRECT: strobes.passThru = 1'b1;
      MODE_LOGIC:  strobes.useNz    = 1'b1;
      MODE_ADD: begin
        strobes.useNz  = 1'b1;
        strobes.useAdd = 1'b1;
      end
      MODE_ADDX: begin
        strobes.useNz  = 1'b1;
        strobes.useAdd = 1'b1;
        strobes.extIn  = 1'b1;
      end
      MODE_SUB: begin
        strobes.useNz  = 1'b1;
        strobes.useSub = 1'b1;
      end
      MODE_SUBX: begin
        strobes.useNz  = 1'b1;
        strobes.useSub = 1'b1;
        strobes.extIn  = 1'b1;
      end
      MODE_CMPB: begin
        strobes.useNz   = 1'b1;
        strobes.useSub  = 1'b1;
        strobes.laneSel = LANE_BYTE;
      end
      MODE_CMPW: begin
        strobes.useNz   = 1'b1;
        strobes.useSub  = 1'b1;
        strobes.laneSel = LANE_HALF;
      end
      MODE_SHIFT: begin
        strobes.useNz    = 1'b1;
        strobes.useShift = 1'b1;
      end
      default: strobes.badMode = 1'b1;
    endcase
  end

endmodule

// File: rtl/deferFlagLane.sv
module deferFlagLane #(
  parameter int W = 32
) (
  input  logic [W-1:0] resIn,
  input  logic [W-1:0] srcIn,
  input  logic         extIn,
  output logic         nFlag,
  output logic         zFlag,
  output logic         addC,
  output logic         addV,
  output logic         subC,
  output logic         subV,
  output logic         shC
);

  logic [W-1:0] extWord;
  logic [W-1:0] otherOp;
  logic [W-1:0] minuend;
  logic [W-1:0] addMix;
  logic [W-1:0] subMix;

  always_comb begin
    extWord = {{(W-1){1'b0}}, extIn};
    // rebuilt operands for the add and subtract families
    otherOp = resIn - srcIn - extWord;
    minuend = resIn + srcIn + extWord;

    zFlag = (resIn == '0);
    nFlag = !zFlag && resIn[W-1];

    addC = extIn ? (resIn <= srcIn) : (resIn < srcIn);
    addMix = (srcIn ^ resIn) & ~(otherOp ^ srcIn);
    addV = addMix[W-1];

    subC = extIn ? (minuend <= srcIn) : (minuend < srcIn);
    subMix = (minuend ^ resIn) & (minuend ^ srcIn);
    subV = subMix[W-1];

    shC = |srcIn;
  end

endmodule

// File: rtl/deferFlagPath.sv
module deferFlagPath
  import deferFlagPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  flagStrobe_t         strobes,
  input  logic [DATA_W-1:0]   resWord,
  input  logic [DATA_W-1:0]   srcWord,
  output logic [FLAG_W-1:0]   flagsOut,
  output logic                errOut
);

  localparam int LANES = 3;
  localparam int LANE_BITS = 7;
  localparam int LANE_W [LANES] = '{DATA_W, HALF_W, BYTE_W};

  // per lane: {n, z, addC, addV, subC, subV, shC}
  logic [LANE_BITS-1:0] laneBits [LANES];
  logic [LANE_BITS-1:0] picked;
  logic [FLAG_W-1:0]    flagsNext;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    deferFlagLane #(.W(LANE_W[g])) uLane (
      .resIn (resWord[LANE_W[g]-1:0]),
      .srcIn (srcWord[LANE_W[g]-1:0]),
      .extIn (strobes.extIn),
      .nFlag (laneBits[g][6]),
      .zFlag (laneBits[g][5]),
      .addC  (laneBits[g][4]),
      .addV  (laneBits[g][3]),
      .subC  (laneBits[g][2]),
      .subV  (laneBits[g][1]),
      .shC   (laneBits[g][0])
    );
  end

  always_comb begin
    unique case (strobes.laneSel)
      LANE_HALF: picked = laneBits[1];
      LANE_BYTE: picked = laneBits[2];
      default:   picked = laneBits[0];
    endcase
  end

  always_comb begin
    flagsNext = '0;
    if (strobes.passThru) begin
      flagsNext = resWord[FLAG_W-1:0];
    end else if (strobes.useNz) begin
      flagsNext[3] = picked[6];
      flagsNext[2] = picked[5];
      if (strobes.useAdd) begin
        flagsNext[1] = picked[3];
        flagsNext[0] = picked[4];
      end else if (strobes.useSub) begin
        flagsNext[1] = picked[1];
        flagsNext[0] = picked[2];
      end else if (strobes.useShift) begin
        flagsNext[0] = picked[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsOut <= '0;
      errOut   <= 1'b0;
    end else begin
      flagsOut <= flagsNext;
      errOut   <= strobes.badMode;
    end
  end

  // history guard so $past never reaches before reset
  logic histOk;
  logic wasPass, wasNz, wasLogic, wasShift;
  assign wasLogic = strobes.useNz && !strobes.useAdd && !strobes.useSub && !strobes.useShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histOk   <= 1'b0;
      wasPass  <= 1'b0;
      wasNz    <= 1'b0;
      wasShift <= 1'b0;
    end else begin
      histOk   <= 1'b1;
      wasPass  <= strobes.passThru;
      wasNz    <= strobes.useNz;
      wasShift <= strobes.useShift;
    end
  end

  a_r1_direct_copy: assert property (@(posedge clk) disable iff (!rstN)
    histOk && wasPass |-> flagsOut == $past(resWord[FLAG_W-1:0]));

  a_r2_nz_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    histOk && wasNz |-> !(flagsOut[3] && flagsOut[2]));

  a_r3_logic_no_vc: assert property (@(posedge clk) disable iff (!rstN)
    histOk && $past(wasLogic) |-> flagsOut[1:0] == 2'b00);

  a_r10_shift_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    histOk && wasShift |-> !flagsOut[1]);

  a_r11_error_clears: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> flagsOut == '0);

  a_r12_reset_clear: assert property (@(posedge clk)
    !$past(rstN) && !histOk |-> flagsOut == '0 && !errOut);

endmodule

// File: rtl/deferFlagUnit.sv
module deferFlagUnit
  import deferFlagPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        modeCode,
  input  logic [DATA_W-1:0] resWord,
  input  logic [DATA_W-1:0] srcWord,
  output logic [3:0]        flagsOut,
  output logic              errOut
);

  flagStrobe_t strobes;

  deferFlagCtrl uCtrl (
    .modeCode (modeCode),
    .strobes  (strobes)
  );

  deferFlagPath #(
    .DATA_W (DATA_W),
    .HALF_W (HALF_W),
    .BYTE_W (BYTE_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .resWord  (resWord),
    .srcWord  (srcWord),
    .flagsOut (flagsOut),
    .errOut   (errOut)
  );

endmodule

// File: tb/tb_deferFlagUnit.sv
`timescale 1ns/1ps
module tb_deferFlagUnit;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  modeCode;
  logic [31:0] resWord;
  logic [31:0] srcWord;
  logic [3:0]  flagsOut;
  logic        errOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  deferFlagUnit dut (
    .clk(clk), .rstN(rstN), .modeCode(modeCode),
    .resWord(resWord), .srcWord(srcWord),
    .flagsOut(flagsOut), .errOut(errOut)
  );

  // behavioural model: returns {err, N, Z, V, C}
  function automatic logic [4:0] refEval(int mode, logic [31:0] r, logic [31:0] s);
    longint unsigned mask, top, rv, sv, m, op;
    int w;
    bit n, z, v, c;
    if (mode == 0) return {1'b0, r[3:0]};
    if (mode > 8) return 5'b10000;
    w = (mode == 4) ? 8 : (mode == 5) ? 16 : 32;
    mask = (64'd1 << w) - 1;
    top  = 64'd1 << (w - 1);
    rv = r & mask;
    sv = s & mask;
    z = (rv == 0);
    n = !z && ((rv & top) != 0);
    v = 0; c = 0;
    case (mode)
      2, 6: begin
        op = (mode == 6) ? ((rv - sv - 1) & mask) : ((rv - sv) & mask);
        c  = (mode == 6) ? (rv <= sv) : (rv < sv);
        v  = ((op & top) == (sv & top)) && ((rv & top) != (sv & top));
      end
      3, 4, 5, 7: begin
        m = (mode == 7) ? ((rv + sv + 1) & mask) : ((rv + sv) & mask);
        c = (mode == 7) ? (m <= sv) : (m < sv);
        v = ((m & top) != (sv & top)) && ((m & top) != (rv & top));
      end
      8: c = (s != 0);
      default: ;
    endcase
    return {1'b0, n, z, v, c};
  endfunction

  function automatic string tagOf(int mode);
    case (mode)
      0: return "R1";
      1: return "R3+R2";
      2: return "R4+R2";
      3: return "R6+R2";
      4: return "R8+R2";
      5: return "R9+R2";
      6: return "R5+R2";
      7: return "R7+R2";
      8: return "R10+R2";
      default: return "R11";
    endcase
  endfunction

  // drive at a falling edge, compare one clock later (R12 latency)
  task automatic step(int mode, logic [31:0] r, logic [31:0] s);
    logic [4:0] exp;
    modeCode = mode[3:0];
    resWord  = r;
    srcWord  = s;
    exp = refEval(mode, r, s);
    @(negedge clk);
    checks++;
    if ({errOut, flagsOut} !== exp) begin
      failures++;
      $display("FAIL %s mode=%0d res=%h src=%h actual=%b expected=%b",
               tagOf(mode), mode, r, s, {errOut, flagsOut}, exp);
    end
  endtask

  function automatic logic [31:0] nextRand(logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13;
    y ^= y >> 17;
    y ^= y << 5;
    return y;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    modeCode = 4'd2;
    resWord = 32'hFFFF_FFFF;
    srcWord = 32'h0000_0001;
    repeat (3) @(negedge clk);
    checks++;
    if (flagsOut !== 4'b0000 || errOut !== 1'b0) begin
      failures++;
      $display("FAIL R12 reset actual=%b expected=00000", {errOut, flagsOut});
    end
    rstN = 1'b1;

    // R1 direct pass-through
    step(0, 32'hABCD_0005, 32'h0);
    step(0, 32'h0000_000A, 32'hFFFF_FFFF);
    // R3 logic
    step(1, 32'h0, 32'h5);
    step(1, 32'h8000_0000, 32'h0);
    // R4 add
    step(2, 32'h0, 32'h0);
    step(2, 32'h8000_0000, 32'h1);
    step(2, 32'h0000_0001, 32'h0000_0002);
    step(2, 32'h7FFF_FFFF, 32'h8000_0000);
    // R5 add with extend
    step(6, 32'h0000_0007, 32'h0000_0007);
    step(6, 32'h8000_0000, 32'h0000_0000);
    // R6 subtract
    step(3, 32'h7FFF_FFFF, 32'h0000_0001);
    step(3, 32'hFFFF_FFFF, 32'h0000_0001);
    step(3, 32'h0, 32'h0);
    // R7 subtract with extend
    step(7, 32'hFFFF_FFFF, 32'h0000_0000);
    step(7, 32'h7FFF_FFFF, 32'h0000_0000);
    // R8 byte compare with dirty upper bits
    step(4, 32'hFFFF_FF00, 32'h1234_5600);
    step(4, 32'h0000_007F, 32'hFFFF_FF01);
    step(4, 32'h5555_55FF, 32'hAAAA_AA01);
    // R9 halfword compare
    step(5, 32'hFFFF_0000, 32'h0000_0000);
    step(5, 32'h0000_7FFF, 32'hFFFF_0001);
    // R10 shift
    step(8, 32'h8000_0000, 32'h0);
    step(8, 32'h0, 32'h1);
    // R11 invalid codes
    for (int k = 9; k < 16; k++) step(k, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    // random sweep over all codes
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      rng = nextRand(rng); a = rng;
      rng = nextRand(rng); b = rng;
      if (i % 7 == 0) b = 32'h0;
      if (i % 11 == 0) a = b;
      step(int'(rng[27:24]), a, b);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule